// File: doc/BRIEF.md
# SPI Slave Shift Engine (16-bit, phase 0)

This block is the receive/transmit data path of a serial peripheral port acting as a bus slave in clock-phase-0 operation. A remote master drives the serial clock, the master-to-slave data line and an active-low select. The engine returns one word per selection on the slave-to-master line. All three serial inputs are brought into the local system clock domain through two-flop synchronisers, and edges are found there. The system clock must run at least four times faster than the serial clock.

The local host hands over one outgoing word through a valid/ready handshake into a single holding register. The engine copies that word into its shifter when select falls and presents the first bit right away, before any serial clock edge. Each leading edge samples the incoming data line. Each trailing edge shifts the register by one place, which takes in the sampled bit and exposes the next outgoing bit. After the sixteenth sample the engine latches the received word and raises a one-cycle done pulse. Clock polarity and bit order are static inputs that may change only while select is high.

The controller has three states. IDLE means not selected, with the output disabled. ACTIVE means selected and counting bits. WAIT means the word is complete and select is still low. The transitions are:
- IDLE→ACTIVE on a select fall, which loads the shifter.
- ACTIVE→IDLE on a select rise, which aborts the word.
- ACTIVE→WAIT on the sixteenth leading edge, which raises the done pulse.
- WAIT→IDLE on a select rise.

Top module: `spi_slave_engine`

## Requirements
- R1: After reset, tx_ready_o is 1, rx_valid_o is 0 and miso_oe_o is 0.
- R2: miso_oe_o is 1 while the synchronised select is low (from a few system cycles after the fall) and 0 after select returns high. While miso_oe_o is 0, miso_o is 0.
- R3: Once select has fallen, and before any serial clock edge, miso_o carries bit 15 of the loaded word when lsb_first_i is 0, or bit 0 when lsb_first_i is 1.
- R4: Outgoing bits leave in order from bit 15 down to bit 0 when lsb_first_i is 0, and from bit 0 up to bit 15 when it is 1. Each new bit appears after a trailing edge. The first incoming bit lands in bit 15 of rx_data_o in MSB-first order, or in bit 0 in LSB-first order.
- R5: The sixteenth leading edge of a selection raises rx_valid_o for exactly one system cycle, with rx_data_o holding the received word.
- R6: If select rises before sixteen leading edges, no rx_valid_o pulse occurs and the next selection starts again from bit zero.
- R7: After a completed word, further serial clock edges produce no further pulse until select has gone high and then low again.
- R8: With cpol_i at 0 the leading edge is the rising edge. With cpol_i at 1 it is the falling edge.
- R9: tx_ready_o is 1 exactly when the holding register is empty. A word is accepted when tx_valid_i and tx_ready_o are both 1. The holding register is emptied when select falls. If it is empty at that moment, sixteen zero bits are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the master (asynchronous) |
| mosi_i | input | 1 | Master-to-slave data line (asynchronous) |
| sel_n_i | input | 1 | Active-low slave select (asynchronous) |
| cpol_i | input | 1 | Clock polarity: idle level of sck_i |
| lsb_first_i | input | 1 | 1 selects least-significant-bit-first order |
| tx_data_i | input | 16 | Word offered for transmission |
| tx_valid_i | input | 1 | Host offers tx_data_i |
| tx_ready_o | output | 1 | Holding register is empty |
| rx_data_o | output | 16 | Last received word |
| rx_valid_o | output | 1 | One-cycle pulse: a word has been received |
| miso_o | output | 1 | Slave-to-master data line |
| miso_oe_o | output | 1 | Output enable for miso_o |

## Verification
The assertions check on every cycle that the done pulse lasts one cycle and only happens while the output is enabled. They also check that at most one pulse falls within one selection, that a disabled output is held at 0, and that the holding register's ready flag behaves correctly around a handshake and a select fall. The bench's scenarios are the only evidence of the actual bit values: first-bit presentation, outgoing order under both bit orders and both polarities, assembly of the received word, discarding of an aborted partial word, and the zero word sent when no data was offered.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACTIVE = 2'd1,
        S_WAIT   = 2'd2
    } eng_state_e;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int          WIDTH  = 3,
    parameter int          STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_edge_unit.sv
module spi_edge_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic sel_s,
    input  logic cpol,
    output logic lead,
    output logic trail,
    output logic sel_fall,
    output logic sel_rise
);
    logic sck_norm;
    logic sck_prev_q;
    logic sel_prev_q;

    // fold polarity so that the leading edge is always a 0->1 change
    assign sck_norm = sck_s ^ cpol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            sel_prev_q <= 1'b1;
        end else begin
            sck_prev_q <= sck_norm;
            sel_prev_q <= sel_s;
        end
    end

    assign lead     =  sck_norm & ~sck_prev_q;
    assign trail    = ~sck_norm &  sck_prev_q;
    assign sel_fall = ~sel_s &  sel_prev_q;
    assign sel_rise =  sel_s & ~sel_prev_q;
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift_en,
    input  logic              lead,
    input  logic              trail,
    input  logic              mosi_s,
    input  logic              lsb_first,
    output logic              out_bit,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] shreg_q;
    logic              sample_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            sample_q <= 1'b0;
        end else if (load) begin
            shreg_q <= load_word;
        end else if (shift_en) begin
            if (lead) sample_q <= mosi_s;
            if (trail) begin
                if (lsb_first) shreg_q <= {sample_q, shreg_q[WORD_W-1:1]};
                else           shreg_q <= {shreg_q[WORD_W-2:0], sample_q};
            end
        end
    end

    assign out_bit = lsb_first ? shreg_q[0] : shreg_q[WORD_W-1];
    // complete word as seen at the final leading edge, bit taken live
    assign rx_word = lsb_first ? {mosi_s, shreg_q[WORD_W-1:1]}
                               : {shreg_q[WORD_W-2:0], mosi_s};
endmodule

// File: rtl/spi_slave_engine.sv
module spi_slave_engine
    import spi_slave_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              sel_n_i,
    input  logic              cpol_i,
    input  logic              lsb_first_i,
    input  logic [WORD_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              miso_o,
    output logic              miso_oe_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    logic [2:0] pins_s;
    logic       sck_s, mosi_s, sel_s;
    logic       lead, trail, sel_fall, sel_rise;

    eng_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic        last_bit;
    logic        load, shift_en, done;

    logic              tx_full_q;
    logic [WORD_W-1:0] tx_hold_q;
    logic [WORD_W-1:0] rx_word;
    logic              out_bit;
    logic [WORD_W-1:0] rx_data_q;
    logic              rx_valid_q;

    spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({sel_n_i, mosi_i, sck_i}),
        .sync_o (pins_s)
    );
    assign sck_s  = pins_s[0];
    assign mosi_s = pins_s[1];
    assign sel_s  = pins_s[2];

    spi_edge_unit i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (sck_s),
        .sel_s   (sel_s),
        .cpol    (cpol_i),
        .lead    (lead),
        .trail   (trail),
        .sel_fall(sel_fall),
        .sel_rise(sel_rise)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign last_bit = (cnt_q == LAST_BIT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (sel_fall) state_d = S_ACTIVE;
            S_ACTIVE: begin
                if (sel_rise)             state_d = S_IDLE;
                else if (lead && last_bit) state_d = S_WAIT;
            end
            S_WAIT:   if (sel_rise) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        load      = 1'b0;
        shift_en  = 1'b0;
        done      = 1'b0;
        miso_oe_o = 1'b0;
        unique case (state_q)
            S_IDLE:   load = sel_fall;
            S_ACTIVE: begin
                shift_en  = ~sel_rise;
                done      = ~sel_rise & lead & last_bit;
                miso_oe_o = 1'b1;
            end
            S_WAIT:   miso_oe_o = 1'b1;
            default:  ;
        endcase
    end

    // bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (load)             cnt_q <= '0;
        else if (shift_en && lead) cnt_q <= cnt_q + 1'b1;
    end

    // single-word transmit holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_full_q <= 1'b0;
            tx_hold_q <= '0;
        end else begin
            if (load) tx_full_q <= 1'b0;
            if (tx_valid_i && !tx_full_q) begin
                tx_full_q <= 1'b1;
                tx_hold_q <= tx_data_i;
            end
        end
    end
    assign tx_ready_o = ~tx_full_q;

    spi_shifter #(.WORD_W(WORD_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_word(tx_full_q ? tx_hold_q : '0),
        .shift_en (shift_en),
        .lead     (lead),
        .trail    (trail),
        .mosi_s   (mosi_s),
        .lsb_first(lsb_first_i),
        .out_bit  (out_bit),
        .rx_word  (rx_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
        end else begin
            rx_valid_q <= done;
            if (done) rx_data_q <= rx_word;
        end
    end

    assign rx_valid_o = rx_valid_q;
    assign rx_data_o  = rx_data_q;
    assign miso_o     = miso_oe_o & out_bit;
endmodule

// File: rtl/spi_slave_engine_chk.sv
module spi_slave_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_valid_i,
    input logic tx_ready_o,
    input logic rx_valid_o,
    input logic miso_o,
    input logic miso_oe_o
);
    logic word_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          word_seen_q <= 1'b0;
        else if (!miso_oe_o) word_seen_q <= 1'b0;
        else if (rx_valid_o) word_seen_q <= 1'b1;
    end

    // R5
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R5
    done_while_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> miso_oe_o);

    // R7
    one_word_per_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> !word_seen_q);

    // R2
    quiet_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe_o |-> !miso_o);

    // R9
    accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

    // R9
    select_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(miso_oe_o) && !$past(tx_valid_i)) |-> tx_ready_o);
endmodule

bind spi_slave_engine spi_slave_engine_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o),
    .rx_valid_o(rx_valid_o),
    .miso_o    (miso_o),
    .miso_oe_o (miso_oe_o)
);

// File: tb/test_spi_slave_engine.sv
`timescale 1ns/1ps
module test_spi_slave_engine;
    localparam int W    = 16;
    localparam int HALF = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck = 1'b0, mosi = 1'b0, sel_n = 1'b1, cpol = 1'b0, lsbf = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         tx_valid = 1'b0;
    logic         tx_ready, rx_valid, miso, miso_oe;
    logic [W-1:0] rx_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] exp_q [$];
    bit finished = 0;

    always #4 clk = ~clk;

    spi_slave_engine i_spi_slave_engine (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .sel_n_i(sel_n),
        .cpol_i(cpol), .lsb_first_i(lsbf), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
        .tx_ready_o(tx_ready), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
        .miso_o(miso), .miso_oe_o(miso_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // monitor: pops the expected word on every done pulse
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                check("R6/R7 unexpected done pulse", 16'h0001, 16'h0000);
            end else begin
                check("R5 received word", rx_data, exp_q.pop_front());
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic give_tx(input logic [W-1:0] w);
        @(negedge clk);
        tx_data  = w;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        check("R9 ready low after accept", {15'd0, tx_ready}, 16'd0);
    endtask

    // master side: sends nbits of rxw, then extra clock periods, checks MISO
    task automatic xfer(input logic [W-1:0] txw, input logic [W-1:0] rxw,
                        input int nbits, input int extra);
        logic [W-1:0] got;
        logic [W-1:0] want;
        got  = '0;
        want = '0;
        @(negedge clk);
        sck   = cpol;
        sel_n = 1'b0;
        if (nbits == W) exp_q.push_back(rxw);
        wait_n(HALF);
        check("R2 enable while selected", {15'd0, miso_oe}, 16'd1);
        check("R3 first bit before any edge", {15'd0, miso},
              {15'd0, lsbf ? txw[0] : txw[W-1]});
        for (int i = 0; i < nbits + extra; i++) begin
            mosi = (i < W) ? (lsbf ? rxw[i] : rxw[W-1-i]) : 1'b1;
            wait_n(HALF);
            if (i < nbits && i < W) begin
                got[i]  = miso;
                want[i] = lsbf ? txw[i] : txw[W-1-i];
            end
            sck = ~cpol;          // leading edge (R8)
            wait_n(HALF);
            sck = cpol;           // trailing edge
        end
        check("R4 outgoing bit stream", got, want);
        wait_n(HALF);
        sel_n = 1'b1;
        wait_n(HALF);
        check("R2 disabled after deselect", {15'd0, miso_oe}, 16'd0);
        check("R2 output quiet when disabled", {15'd0, miso}, 16'd0);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        // R1 reset state
        check("R1 tx_ready after reset", {15'd0, tx_ready}, 16'd1);
        check("R1 rx_valid after reset", {15'd0, rx_valid}, 16'd0);
        check("R1 miso_oe after reset", {15'd0, miso_oe}, 16'd0);

        // R4 MSB first, R8 cpol 0
        cpol = 0; lsbf = 0;
        give_tx(16'hA5C3);
        xfer(16'hA5C3, 16'h1234, W, 0);
        check("R9 holding emptied by select", {15'd0, tx_ready}, 16'd1);

        // R4 LSB first
        lsbf = 1;
        give_tx(16'h8001);
        xfer(16'h8001, 16'hF00D, W, 0);

        // R8 cpol 1, both orders
        cpol = 1; lsbf = 0;
        wait_n(HALF);
        sck = 1'b1;
        wait_n(HALF);
        give_tx(16'h7E81);
        xfer(16'h7E81, 16'hBEEF, W, 0);
        lsbf = 1;
        give_tx(16'h3C5A);
        xfer(16'h3C5A, 16'h0F96, W, 0);

        // R6 aborted partial word, then a clean word
        cpol = 0; lsbf = 0;
        sck  = 1'b0;
        wait_n(HALF);
        give_tx(16'hFFFF);
        xfer(16'hFFFF, 16'h0000, 5, 0);
        give_tx(16'h1357);
        xfer(16'h1357, 16'h2468, W, 0);

        // R7 extra edges after a complete word while still selected
        give_tx(16'hCAFE);
        xfer(16'hCAFE, 16'h5A5A, W, 4);

        // R9 nothing offered: zeros sent
        xfer(16'h0000, 16'h9999, W, 0);

        wait_n(20);
        check("R6/R7 all expected words delivered", 16'(exp_q.size()), 16'd0);
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        check("watchdog expired", 16'd1, 16'd0);
        finish_up();
    end
endmodule